// File: doc/BRIEF.md
# Overcurrent Fault Latch Controller

This block supervises two digital health flags of a three-phase inverter stage: an already-synchronized overcurrent comparator flag and a low-side supply-good flag. From them it produces one global gate enable, which permits or blocks all six switch drivers at once, and an active-low fault indication that drives an open-drain style pull-down on a shared fault pin.

An overcurrent flag counts only once it has been seen high on a set number of consecutive clock edges; shorter bursts are treated as noise. An accepted trip starts a timed shutdown that clears by itself after a fixed number of cycles. It restarts at once if the flag is still high when the time runs out. Loss of supply blocks the gates and raises the fault for exactly as long as the supply flag stays low. At power-up the gates stay blocked until the supply flag first goes high. A status bit reports whether the present fault comes from overcurrent or from the supply.

The controller is a four-state machine. States: `ST_BOOT` (waiting for the first supply-good), `ST_RUN` (gates permitted), `ST_OC_HOLD` (timed overcurrent shutdown) and `ST_UV` (supply loss). Transitions: BOOT→RUN when the supply is good. RUN→OC_HOLD on an accepted trip, which wins over a supply drop in the same cycle. RUN→UV on supply loss. OC_HOLD→OC_HOLD (timer restart) when the timer expires with the overcurrent flag still high and the supply good. OC_HOLD→UV when the timer expires with the supply low. OC_HOLD→RUN when the timer expires with the flag low and the supply good. UV→RUN when the supply is good again.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: After reset `gate_en`=0, `fault_n`=0 and `fault_is_oc`=0, and these values hold until the first clock edge that samples `supply_ok`=1. From that edge on, `gate_en`=1 and `fault_n`=1.
- R2: A run of `oc_flag`=1 lasting fewer than TRIP_CYC consecutive sampling edges, followed by a sample of 0, has no effect on any output, and the count starts again from zero.
- R3: While the block is running, the edge that samples `oc_flag`=1 for the TRIP_CYC-th consecutive time sets `gate_en` to 0.
- R4: Throughout an overcurrent shutdown, `fault_n`=0 (pin pulled low) and `fault_is_oc`=1.
- R5: An overcurrent shutdown lasts exactly CLEAR_CYC clock cycles. If `oc_flag`=0 and `supply_ok`=1 at expiry, it releases by itself to `gate_en`=1, `fault_n`=1 and `fault_is_oc`=0.
- R6: If `oc_flag`=1 when the shutdown time expires (with `supply_ok`=1), the shutdown restarts for another full CLEAR_CYC cycles.
- R7: While running, a sample of `supply_ok`=0 sets `gate_en`=0, `fault_n`=0 and `fault_is_oc`=0 until `supply_ok`=1 is sampled. Overcurrent flags during this time do not start a shutdown.
- R8: If `supply_ok`=0 when the shutdown time expires, the block enters the supply-loss state (`fault_is_oc`=0, gates still blocked). While the shutdown lasts, the supply level does not shorten it.
- R9: An accepted trip and a supply drop sampled on the same edge lead to an overcurrent shutdown (`fault_is_oc`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Synchronized overcurrent comparator output, 1 = current above limit |
| supply_ok | input | 1 | Low-side supply-good flag, 1 = above under-voltage threshold |
| gate_en | output | 1 | Global enable for all six gate drivers, 1 = switching permitted |
| fault_n | output | 1 | Open-drain pull-down enable, 0 = fault pin pulled low |
| fault_is_oc | output | 1 | Fault cause, 1 = overcurrent shutdown, 0 = supply cause or no fault |

## Verification
The hardest situations to reach are the ones decided on the single expiry edge of the shutdown timer. These are a re-latch because the flag is still high, a handover to the supply-loss state because the supply dropped during the hold, and a trip that coincides with a supply drop. The bench runs the block with a short trip filter and clear time. It counts edges from the trip edge exactly, so every input change and sample falls on the edge before, at or after expiry. Glitches one edge shorter than the filter are placed back to back, so a counter that fails to reset shows up as a false trip.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_OC_HOLD = 2'd2,
        ST_UV      = 2'd3
    } ctl_state_t;

endpackage

// File: rtl/oc_trip_filter.sv
module oc_trip_filter #(
    parameter int TRIP_CYC = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    output logic trip
);
    localparam int CW = (TRIP_CYC > 1) ? $clog2(TRIP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

    logic [CW-1:0] run_cnt;

    // Consecutive-high counter, saturating one short of the filter length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!oc_flag) begin
            run_cnt <= '0;
        end else if (run_cnt != LAST) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Accepted on the edge that samples the TRIP_CYC-th consecutive high
    assign trip = oc_flag && (run_cnt == LAST);

endmodule

// File: rtl/oc_clear_timer.sv
module oc_clear_timer #(
    parameter int CLEAR_CYC = 6500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);
    localparam int CW = (CLEAR_CYC > 1) ? $clog2(CLEAR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

    logic [CW-1:0] tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (!run || restart) begin
            tick <= '0;
        end else if (tick != LAST) begin
            tick <= tick + 1'b1;
        end
    end

    assign done = run && (tick == LAST);

endmodule

// File: rtl/oc_fault_fsm.sv
module oc_fault_fsm
    import ocp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic oc_flag,
    input  logic trip,
    input  logic tmr_done,
    output logic tmr_run,
    output logic tmr_restart,
    output logic gate_en,
    output logic fault_n,
    output logic fault_is_oc
);
    ctl_state_t state, state_nx;

    // Next-state logic
    always_comb begin
        state_nx    = state;
        tmr_restart = 1'b0;
        unique case (state)
            ST_BOOT: begin
                if (supply_ok) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (trip)            state_nx = ST_OC_HOLD;
                else if (!supply_ok) state_nx = ST_UV;
            end
            ST_OC_HOLD: begin
                if (tmr_done) begin
                    if (!supply_ok) begin
                        state_nx = ST_UV;
                    end else if (oc_flag) begin
                        state_nx    = ST_OC_HOLD;
                        tmr_restart = 1'b1;
                    end else begin
                        state_nx = ST_RUN;
                    end
                end
            end
            ST_UV: begin
                if (supply_ok) state_nx = ST_RUN;
            end
            default: state_nx = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // Moore outputs
    always_comb begin
        gate_en     = 1'b0;
        fault_n     = 1'b0;
        fault_is_oc = 1'b0;
        tmr_run     = 1'b0;
        unique case (state)
            ST_BOOT: ;
            ST_RUN: begin
                gate_en = 1'b1;
                fault_n = 1'b1;
            end
            ST_OC_HOLD: begin
                fault_is_oc = 1'b1;
                tmr_run     = 1'b1;
            end
            ST_UV: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl #(
    parameter int TRIP_CYC  = 53,
    parameter int CLEAR_CYC = 6500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic supply_ok,
    output logic gate_en,
    output logic fault_n,
    output logic fault_is_oc
);
    logic trip;
    logic tmr_run;
    logic tmr_restart;
    logic tmr_done;

    oc_trip_filter #(.TRIP_CYC(TRIP_CYC)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_flag (oc_flag),
        .trip    (trip)
    );

    oc_clear_timer #(.CLEAR_CYC(CLEAR_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (tmr_restart),
        .done    (tmr_done)
    );

    oc_fault_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .oc_flag     (oc_flag),
        .trip        (trip),
        .tmr_done    (tmr_done),
        .tmr_run     (tmr_run),
        .tmr_restart (tmr_restart),
        .gate_en     (gate_en),
        .fault_n     (fault_n),
        .fault_is_oc (fault_is_oc)
    );

endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
module ocp_fault_ctrl_chk #(
    parameter int TRIP_CYC  = 53,
    parameter int CLEAR_CYC = 6500
) (
    input logic clk,
    input logic rst_n,
    input logic oc_flag,
    input logic supply_ok,
    input logic gate_en,
    input logic fault_n,
    input logic fault_is_oc
);
    int unsigned oc_run;
    int unsigned hold_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_run   <= 0;
            hold_len <= 0;
        end else begin
            oc_run   <= !oc_flag ? 0 : ((oc_run < TRIP_CYC) ? oc_run + 1 : oc_run);
            hold_len <= !fault_is_oc ? 0 : ((hold_len < CLEAR_CYC) ? hold_len + 1 : hold_len);
        end
    end

    // R1
    gate_open_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !$past(gate_en)) |-> $past(supply_ok));

    // R2
    trip_after_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_is_oc) |-> (oc_run >= TRIP_CYC));

    // R4
    oc_hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_is_oc |-> (!gate_en && !fault_n));

    // R5
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_is_oc && hold_len < CLEAR_CYC - 1) |=> fault_is_oc);

    // R7
    uv_stays_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !gate_en && !fault_is_oc) |=> !gate_en);

endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk #(
    .TRIP_CYC  (TRIP_CYC),
    .CLEAR_CYC (CLEAR_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .oc_flag     (oc_flag),
    .supply_ok   (supply_ok),
    .gate_en     (gate_en),
    .fault_n     (fault_n),
    .fault_is_oc (fault_is_oc)
);

// File: tb/test_ocp_fault_ctrl.sv
module test_ocp_fault_ctrl;

    localparam int TRIP  = 4;
    localparam int CLEAR = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0;
    logic supply_ok = 1'b0;
    logic gate_en, fault_n, fault_is_oc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ocp_fault_ctrl #(.TRIP_CYC(TRIP), .CLEAR_CYC(CLEAR)) i_ocp_fault_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .oc_flag     (oc_flag),
        .supply_ok   (supply_ok),
        .gate_en     (gate_en),
        .fault_n     (fault_n),
        .fault_is_oc (fault_is_oc)
    );

    typedef struct packed {
        logic       oc;
        logic       sok;
        logic [7:0] edges;
        logic       g;
        logic       f;
        logic       c;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 1'b0, 4'd1}, // R1 boot, no supply yet
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd1}, // R1 first supply-good
        '{1'b1, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0, 4'd2}, // R2 three highs only
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd2}, // R2 glitch rejected
        '{1'b1, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0, 4'd2}, // R2 counter restarted
        '{1'b1, 1'b1, 8'd1,  1'b0, 1'b0, 1'b1, 4'd3}, // R3 fourth high trips
        '{1'b0, 1'b1, 8'd18, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 hold in progress
        '{1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 1'b1, 4'd5}, // R5 last hold cycle
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd5}, // R5 auto release
        '{1'b1, 1'b1, 8'd4,  1'b0, 1'b0, 1'b1, 4'd3}, // R3 second trip
        '{1'b1, 1'b1, 8'd20, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 re-latch at expiry
        '{1'b0, 1'b1, 8'd19, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 full second hold
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd6}, // R6 release after re-latch
        '{1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd7}, // R7 supply loss
        '{1'b0, 1'b0, 8'd30, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 stays blocked
        '{1'b1, 1'b0, 8'd10, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 trip ignored
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd7}, // R7 resume
        '{1'b1, 1'b1, 8'd4,  1'b0, 1'b0, 1'b1, 4'd3}, // R3 trip
        '{1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 hold kept during loss
        '{1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 handover to UV
        '{1'b0, 1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd8}, // R8 resume
        '{1'b1, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0, 4'd9}, // R9 arm filter
        '{1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 1'b1, 4'd9}, // R9 trip wins over loss
        '{1'b0, 1'b1, 8'd20, 1'b1, 1'b1, 1'b0, 4'd9}  // R9 release
    };

    task automatic check(input logic g, input logic f, input logic c, input string req);
        checks++;
        if (gate_en !== g || fault_n !== f || fault_is_oc !== c) begin
            errors++;
            $display("FAIL %s: gate_en/fault_n/fault_is_oc = %b%b%b expected %b%b%b",
                     req, gate_en, fault_n, fault_is_oc, g, f, c);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 1'b0, 1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            oc_flag   = VEC[i].oc;
            supply_ok = VEC[i].sok;
            repeat (int'(VEC[i].edges)) @(posedge clk);
            @(negedge clk);
            check(VEC[i].g, VEC[i].f, VEC[i].c, $sformatf("R%0d vec %0d", VEC[i].req, i));
        end

        // R1: reset during an overcurrent hold returns to boot
        oc_flag = 1'b1;
        repeat (TRIP) @(posedge clk);
        @(negedge clk);
        check(1'b0, 1'b0, 1'b1, "R3 trip before reset");
        rst_n = 1'b0;
        oc_flag = 1'b0;
        @(negedge clk);
        check(1'b0, 1'b0, 1'b0, "R1 reset mid-hold");
        rst_n = 1'b1;
        supply_ok = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1'b1, 1'b1, 1'b0, "R1 start after reset");

        // R2: filter count cleared by reset, one short of TRIP does nothing
        oc_flag = 1'b1;
        repeat (TRIP - 1) @(posedge clk);
        @(negedge clk);
        check(1'b1, 1'b1, 1'b0, "R2 short run after reset");
        oc_flag = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1'b1, 1'b1, 1'b0, "R2 run ended");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule